// File: doc/BRIEF.md
# Accumulator with Merged Arithmetic Unit

This block is a 16-bit working register that doubles as the result store of an arithmetic/logic unit. The unit's two operands are always the register's own value and the word currently presented on the data bus. A select control decides what the register takes in when it is written. It can take the unit's result, so that it acts as an accumulator. It can also take the bus word unchanged, so that it acts as an ordinary general register.

Three controls are separate: selection, latching and driving. A write strobe commits the selected input at the next clock edge. An output enable places the stored value on the outgoing bus lines. A 3-bit function code picks the operation. Carry and zero flags record the outcome of arithmetic and logic writes only.

The shared bus is modelled as two signals. The outgoing side is a data word plus a drive-enable that a bus fabric outside this block combines with other sources. The incoming side is a plain data input.

Top module: `accum_unit`

## Requirements
- R1: While rst_n is low, and at the first edge after it rises, the stored value is 0 and both carry_flag and zero_flag are 0.
- R2: When wr_en is 1 and alu_sel is 0, the stored value becomes bus_in at the next rising edge.
- R3: When wr_en and alu_sel are both 1, the stored value becomes the unit result computed from the prior stored value A and bus_in B.
- R4: fn code 3'b000 gives A+B modulo 2^16. Code 3'b001 gives A-B modulo 2^16.
- R5: fn codes for the logic and pass operations:
  - 3'b010 gives A AND B.
  - 3'b011 gives A OR B.
  - 3'b100 gives A XOR B.
  - 3'b101 gives NOT A.
  - 3'b110 gives B.
  - 3'b111 gives A.
- R6: On a unit write, carry_flag becomes the carry out of bit 15 for an add, and the borrow (1 when A < B unsigned) for a subtract. It becomes 0 for every other code.
- R7: On a unit write, zero_flag becomes 1 exactly when the new stored value is 0.
- R8: The flags keep their values on a plain bus load and on any cycle without wr_en.
- R9: When wr_en is 0, the stored value is unchanged whatever alu_sel, fn and bus_in are.
- R10: bus_oe equals drive_en in the same cycle. bus_out equals the stored value when drive_en is 1 and is 0 otherwise.
- R11: When drive_en and wr_en are both 1 in one cycle, bus_out shows the value held before the edge. The new value appears after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_in | input | 16 | Word currently on the data bus |
| fn | input | 3 | Operation code for the unit |
| alu_sel | input | 1 | 1: write takes unit result; 0: write takes bus_in |
| wr_en | input | 1 | Commit the selected input at the next edge |
| drive_en | input | 1 | Put the stored value on the outgoing bus |
| bus_out | output | 16 | Stored value when driving, else 0 |
| bus_oe | output | 1 | Drive-enable toward the bus fabric |
| carry_flag | output | 1 | Carry/borrow of the last unit write |
| zero_flag | output | 1 | Zero result of the last unit write |

## Verification
Two things can happen in the same cycle: reading the register onto the bus and writing it. The bench provokes this by raising drive_en and wr_en together. It judges the result by sampling bus_out before the edge, where it must show the old value. After the edge, the value read back must be the new one. A second overlap is a plain load that follows a unit write. There the stored value changes, but both flags must keep what the unit write produced.

// File: rtl/accum_pkg.sv
`timescale 1ns/1ps
// Shared types for the accumulator unit.
// Assumes a 3-bit operation code; the encoding is fixed by the requirements.
package accum_pkg;
    typedef enum logic [2:0] {
        OP_ADD   = 3'b000,
        OP_SUB   = 3'b001,
        OP_AND   = 3'b010,
        OP_OR    = 3'b011,
        OP_XOR   = 3'b100,
        OP_NOTA  = 3'b101,
        OP_PASSB = 3'b110,
        OP_PASSA = 3'b111
    } alu_op_e;
endpackage

// File: rtl/accum_alu.sv
`timescale 1ns/1ps
// Combinational arithmetic/logic unit.
// Operands are the stored value (a_i) and the bus word (b_i).
// The carry is the carry out for add and the borrow for subtract; it is 0 otherwise.
// Purely combinational, so it assumes its caller registers the result.
module accum_alu
    import accum_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  alu_op_e      op_i,
    output logic [W-1:0] res_o,
    output logic         cy_o
);
    localparam int WX = W + 1;

    logic [WX-1:0] sum_x;
    logic [WX-1:0] dif_x;

    // Widened add and subtract, so carry and borrow land in the top bit.
    always_comb begin
        sum_x = {1'b0, a_i} + {1'b0, b_i};
        dif_x = {1'b0, a_i} - {1'b0, b_i};
    end

    // Select the result and carry for the requested operation.
    always_comb begin
        res_o = '0;
        cy_o  = 1'b0;
        case (op_i)
            OP_ADD:   begin res_o = sum_x[W-1:0]; cy_o = sum_x[W]; end
            OP_SUB:   begin res_o = dif_x[W-1:0]; cy_o = dif_x[W]; end
            OP_AND:   res_o = a_i & b_i;
            OP_OR:    res_o = a_i | b_i;
            OP_XOR:   res_o = a_i ^ b_i;
            OP_NOTA:  res_o = ~a_i;
            OP_PASSB: res_o = b_i;
            OP_PASSA: res_o = a_i;
            default:  res_o = '0;
        endcase
    end
endmodule

// File: rtl/accum_mux.sv
`timescale 1ns/1ps
// Two-way input selector in front of the register.
// sel_i = 1 picks the unit result; sel_i = 0 picks the raw bus word.
module accum_mux #(
    parameter int W = 16
) (
    input  logic         sel_i,
    input  logic [W-1:0] alu_i,
    input  logic [W-1:0] bus_i,
    output logic [W-1:0] d_o
);
    // Choose the word the register will take on a write.
    always_comb d_o = sel_i ? alu_i : bus_i;
endmodule

// File: rtl/accum_store.sv
`timescale 1ns/1ps
// Holds the stored value and the two status flags.
// The value updates on wr_i. The flags update only when wr_i and flag_upd_i are both 1.
// Reset is synchronous and active low.
module accum_store #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic         flag_upd_i,
    input  logic [W-1:0] d_i,
    input  logic         cy_i,
    output logic [W-1:0] q_o,
    output logic         cy_o,
    output logic         z_o
);
    // Data register: latch the selected word on a write.
    always_ff @(posedge clk) begin
        if (!rst_n)    q_o <= '0;
        else if (wr_i) q_o <= d_i;
    end

    // Flag registers: record the outcome of unit writes only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cy_o <= 1'b0;
            z_o  <= 1'b0;
        end else if (wr_i && flag_upd_i) begin
            cy_o <= cy_i;
            z_o  <= (d_i == '0);
        end
    end
endmodule

// File: rtl/accum_unit.sv
`timescale 1ns/1ps
// Top of the accumulator unit: unit, input selector, register and bus driver.
// Assumes an external fabric merges bus_out/bus_oe with the other bus sources.
module accum_unit
    import accum_pkg::*;
#(
    parameter int W  = 16,
    parameter int FW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  bus_in,
    input  logic [FW-1:0] fn,
    input  logic          alu_sel,
    input  logic          wr_en,
    input  logic          drive_en,
    output logic [W-1:0]  bus_out,
    output logic          bus_oe,
    output logic          carry_flag,
    output logic          zero_flag
);
    logic [W-1:0] acc_q;
    logic [W-1:0] alu_res;
    logic [W-1:0] d_sel;
    logic         alu_cy;
    alu_op_e      op;

    // Map the raw code onto the operation type.
    always_comb op = alu_op_e'(fn[2:0]);

    accum_alu #(.W(W)) u_alu (
        .a_i  (acc_q),
        .b_i  (bus_in),
        .op_i (op),
        .res_o(alu_res),
        .cy_o (alu_cy)
    );

    accum_mux #(.W(W)) u_mux (
        .sel_i(alu_sel),
        .alu_i(alu_res),
        .bus_i(bus_in),
        .d_o  (d_sel)
    );

    accum_store #(.W(W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (wr_en),
        .flag_upd_i(alu_sel),
        .d_i       (d_sel),
        .cy_i      (alu_cy),
        .q_o       (acc_q),
        .cy_o      (carry_flag),
        .z_o       (zero_flag)
    );

    // Bus driver: present the stored value only while enabled.
    always_comb begin
        bus_oe  = drive_en;
        bus_out = drive_en ? acc_q : '0;
    end
endmodule

// File: rtl/accum_unit_chk.sv
`timescale 1ns/1ps
// Property checker for accum_unit, attached with bind.
module accum_unit_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] bus_in,
    input logic [2:0]   fn,
    input logic         alu_sel,
    input logic         wr_en,
    input logic         drive_en,
    input logic [W-1:0] bus_out,
    input logic         bus_oe,
    input logic         carry_flag,
    input logic         zero_flag,
    input logic [W-1:0] acc_q
);
    // R2
    load_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !alu_sel) |=> (acc_q == $past(bus_in)));

    // R4
    add_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && alu_sel && fn == 3'b000) |=> (acc_q == W'($past(acc_q) + $past(bus_in))));

    // R9
    hold_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(acc_q));

    // R8
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && alu_sel) |=> ($stable(carry_flag) && $stable(zero_flag)));

    // R7
    zero_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && alu_sel) |=> (zero_flag == (acc_q == '0)));

    // R10
    drive_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe == drive_en) && (drive_en ? (bus_out == acc_q) : (bus_out == '0)));
endmodule

bind accum_unit accum_unit_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_in    (bus_in),
    .fn        (fn),
    .alu_sel   (alu_sel),
    .wr_en     (wr_en),
    .drive_en  (drive_en),
    .bus_out   (bus_out),
    .bus_oe    (bus_oe),
    .carry_flag(carry_flag),
    .zero_flag (zero_flag),
    .acc_q     (acc_q)
);

// File: tb/sim_accum_unit.sv
`timescale 1ns/1ps
module sim_accum_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_in = '0;
    logic [2:0]  fn = '0;
    logic        alu_sel = 1'b0;
    logic        wr_en = 1'b0;
    logic        drive_en = 1'b0;
    logic [15:0] bus_out;
    logic        bus_oe;
    logic        carry_flag;
    logic        zero_flag;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [15:0] m_acc = '0;
    logic        m_cy = 1'b0;
    logic        m_z = 1'b0;

    always #2 clk = ~clk;

    accum_unit u0 (
        .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .fn(fn), .alu_sel(alu_sel),
        .wr_en(wr_en), .drive_en(drive_en), .bus_out(bus_out), .bus_oe(bus_oe),
        .carry_flag(carry_flag), .zero_flag(zero_flag)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference model of the unit taken from the requirements.
    function automatic logic [16:0] ref_op(input logic [2:0] f, input logic [15:0] a, input logic [15:0] b);
        logic [16:0] r;
        case (f)
            3'b000: r = {1'b0, a} + {1'b0, b};
            3'b001: r = {1'b0, a} - {1'b0, b};
            3'b010: r = {1'b0, a & b};
            3'b011: r = {1'b0, a | b};
            3'b100: r = {1'b0, a ^ b};
            3'b101: r = {1'b0, ~a};
            3'b110: r = {1'b0, b};
            default: r = {1'b0, a};
        endcase
        return r;
    endfunction

    // One clock with the given inputs; the model follows the same edge.
    task automatic step(input logic [15:0] d, input logic [2:0] f, input logic sel, input logic wr, input logic drv);
        logic [16:0] r;
        @(negedge clk);
        bus_in = d; fn = f; alu_sel = sel; wr_en = wr; drive_en = drv;
        r = ref_op(f, m_acc, d);
        @(posedge clk);
        #1;
        if (wr) begin
            if (sel) begin
                m_acc = r[15:0]; m_cy = r[16]; m_z = (r[15:0] == 16'h0);
            end else begin
                m_acc = d;
            end
        end
        wr_en = 1'b0; drive_en = 1'b0;
    endtask

    // Read the stored value through the bus driver, with no write.
    task automatic peek(input string req);
        @(negedge clk);
        wr_en = 1'b0; drive_en = 1'b1;
        #1;
        chk(req, {16'h0, bus_out}, {16'h0, m_acc});
        drive_en = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        step(16'hFFFF, 3'b000, 1'b1, 1'b1, 1'b0);
        m_acc = '0; m_cy = 0; m_z = 0;
        chk("R1 carry", carry_flag, 0);
        chk("R1 zero", zero_flag, 0);
        @(negedge clk); rst_n = 1'b1;
        peek("R1 value");
    endtask

    task automatic t_load;
        step(16'h1234, 3'b000, 1'b0, 1'b1, 1'b0);
        peek("R2 load");
        step(16'hBEEF, 3'b101, 1'b0, 1'b1, 1'b0);
        peek("R2 load second");
    endtask

    task automatic t_add;
        step(16'hFFF0, 3'b000, 1'b0, 1'b1, 1'b0);
        step(16'h0020, 3'b000, 1'b1, 1'b1, 1'b0);
        peek("R3 R4 add wrap");
        chk("R6 add carry", carry_flag, 1);
        chk("R7 nonzero", zero_flag, 0);
        step(16'h0001, 3'b000, 1'b1, 1'b1, 1'b0);
        peek("R4 add small");
        chk("R6 add no carry", carry_flag, 0);
        step(16'hFFEF, 3'b000, 1'b1, 1'b1, 1'b0);
        peek("R4 add to zero");
        chk("R7 zero after add", zero_flag, 1);
        chk("R6 carry at zero", carry_flag, 1);
    endtask

    task automatic t_sub;
        step(16'h0005, 3'b000, 1'b0, 1'b1, 1'b0);
        step(16'h0007, 3'b001, 1'b1, 1'b1, 1'b0);
        peek("R4 sub borrow value");
        chk("R6 sub borrow", carry_flag, 1);
        step(16'h0FFE, 3'b001, 1'b1, 1'b1, 1'b0);
        peek("R4 sub");
        chk("R6 sub no borrow", carry_flag, 0);
        step(16'hF000, 3'b001, 1'b1, 1'b1, 1'b0);
        chk("R7 sub zero", zero_flag, 1);
    endtask

    task automatic t_logic;
        for (int k = 2; k < 8; k++) begin
            step(16'hA5C3, 3'b000, 1'b0, 1'b1, 1'b0);
            step(16'h0FF0, 3'(k), 1'b1, 1'b1, 1'b0);
            peek($sformatf("R5 code %0d", k));
            chk($sformatf("R6 code %0d carry", k), carry_flag, 0);
        end
    endtask

    task automatic t_hold;
        step(16'h4321, 3'b000, 1'b0, 1'b1, 1'b0);
        step(16'h0000, 3'b000, 1'b1, 1'b1, 1'b0);
        step(16'hFFFF, 3'b000, 1'b1, 1'b0, 1'b0);
        step(16'h1111, 3'b110, 1'b0, 1'b0, 1'b0);
        peek("R9 no write");
        step(16'h0000, 3'b000, 1'b0, 1'b1, 1'b0);
        peek("R2 load zero");
        chk("R8 zero kept on load", zero_flag, 0);
        step(16'hFFFF, 3'b000, 1'b1, 1'b1, 1'b0);
        step(16'h0002, 3'b000, 1'b0, 1'b1, 1'b0);
        chk("R8 carry kept on load", carry_flag, 0);
        step(16'h0000, 3'b110, 1'b1, 1'b1, 1'b0);
        chk("R7 pass zero", zero_flag, 1);
        step(16'h0009, 3'b110, 1'b1, 1'b0, 1'b0);
        chk("R8 zero kept idle", zero_flag, 1);
    endtask

    task automatic t_drive;
        step(16'h7E57, 3'b000, 1'b0, 1'b1, 1'b0);
        @(negedge clk); drive_en = 1'b0; #1;
        chk("R10 oe off", bus_oe, 0);
        chk("R10 out off", bus_out, 0);
        drive_en = 1'b1; #1;
        chk("R10 oe on", bus_oe, 1);
        chk("R10 out on", bus_out, 16'h7E57);
        drive_en = 1'b0;
    endtask

    task automatic t_overlap;
        logic [15:0] old;
        old = m_acc;
        @(negedge clk);
        bus_in = 16'h0101; fn = 3'b000; alu_sel = 1'b1; wr_en = 1'b1; drive_en = 1'b1;
        #1;
        chk("R11 old during write", bus_out, old);
        @(posedge clk); #1;
        m_acc = old + 16'h0101; m_cy = ({1'b0, old} + 17'h0101) >> 16; m_z = (m_acc == 0);
        chk("R11 new after edge", bus_out, m_acc);
        wr_en = 1'b0; drive_en = 1'b0;
        peek("R11 settled");
    endtask

    initial begin
        t_reset();
        t_load();
        t_add();
        t_sub();
        t_logic();
        t_hold();
        t_drive();
        t_overlap();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule